// File: doc/BRIEF.md
# JTAG Debug Byte Channel Data Register

This block sits behind one user-defined JTAG instruction. It gives a host debugger a single 11-bit data register that carries three kinds of traffic. The first is a byte-wide channel in each direction between the host and the CPU. The second is a set of CPU control commands (halt into the debug vector, reset, and memory or CSR service requests). The third is a status readback that the host polls.

Every access scans all 11 bits, least significant bit first. The low three bits of the word shifted in choose the destination: the command register, the host-to-CPU byte slot, or the acknowledgement of the CPU-to-host byte. Each capture loads the status flags and the pending CPU-to-host byte into the register, so the host sees them as it shifts.

Events on the TCK side reach the system clock as toggles. Each toggle passes a two-flop synchronizer and an edge detector. The status flags return to TCK the same way. On the CPU side the block presents two one-entry byte buffers with valid/ready handshakes, plus single-cycle pulses for halt, reset and service requests. The testbench drives the TAP controller's capture, shift and update strobes directly.

Top module: `jdbg_dr_top`

## Requirements
- R1: After reset all status flags read 0, `c2h_ready_o` is 1, and `h2c_valid_o`, `cpu_halt_o`, `cpu_reset_o` and `op_req_o` are 0.
- R2: The data register is 11 bits wide. Each shift step moves `tdi_i` into bit 10 and the register one place toward bit 0, and `tdo_o` presents bit 0. A capture loads the status word: bit 0 is rx-ready, bit 1 is tx-full, bit 2 is busy and bits [10:3] hold the CPU-to-host byte.
- R3: An update whose address field (bits [2:0]) is 1 (TX) takes bits [10:3] as a byte. The block presents that byte on `h2c_data_o` with `h2c_valid_o` high, and tx-full reads 1 until the CPU accepts the byte with `h2c_ready_i`. While the byte is waiting, data and valid stay stable.
- R4: A TX update that arrives while tx-full is set is dropped, and the byte already in the buffer is delivered unchanged.
- R5: The block accepts a CPU byte on `c2h_valid_i` when `c2h_ready_o` is 1. It then sets rx-ready, drops `c2h_ready_o`, and shows the byte in capture bits [10:3].
- R6: An update with address 2 (RX) clears rx-ready and raises `c2h_ready_o` again. The byte stays readable in the next capture.
- R7: A command update (address 0) with opcode 6 in bits [10:7] produces exactly one single-cycle `cpu_halt_o` pulse. Opcode 7 produces exactly one single-cycle `cpu_reset_o` pulse. These pulses never overlap each other or `op_req_o`.
- R8: Command opcodes 1 to 5 produce one single-cycle `op_req_o` pulse, with the opcode on `op_code_o`, and set busy. Busy clears when `op_done_i` is seen.
- R9: Command opcode 0 is a no-op and raises no output pulse.
- R10: An update whose address field is 3 to 7 changes no flag, buffer or output.
- R11: Capture, shift and update strobes have no effect while `dr_sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tck_i | input | 1 | JTAG test clock |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, bit 0 of the register |
| dr_sel_i | input | 1 | This register's instruction is selected |
| dr_capture_i | input | 1 | Capture-DR strobe |
| dr_shift_i | input | 1 | Shift-DR strobe |
| dr_update_i | input | 1 | Update-DR strobe |
| h2c_data_o | output | 8 | Host-to-CPU byte |
| h2c_valid_o | output | 1 | Host-to-CPU byte pending |
| h2c_ready_i | input | 1 | CPU takes the pending byte |
| c2h_data_i | input | 8 | CPU-to-host byte |
| c2h_valid_i | input | 1 | CPU offers a byte |
| c2h_ready_o | output | 1 | CPU-to-host buffer is free |
| cpu_halt_o | output | 1 | Pulse: enter debug vector |
| cpu_reset_o | output | 1 | Pulse: enter reset vector |
| op_req_o | output | 1 | Pulse: memory or CSR service request |
| op_code_o | output | 4 | Opcode of the last service request |
| op_done_i | input | 1 | CPU finished the service request |

## Verification
The bench sends asymmetric bytes such as 0x4E, 0x1D and 0x6B in both directions, so a reversed bit order or a shifted field would show up as a wrong value. It covers the three-scan host read (poll, RX acknowledgement, no-op) and shows that the byte survives the acknowledgement while rx-ready drops. Back-to-back TX writes without a CPU accept separate the buffer's keep-first rule from an overwrite. Each command opcode class is sent, and so are unused addresses and deselected scans, and the pulse counters tell a real pulse apart from a repeated one or a missing one.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DR_W   = ADDR_W + BYTE_W;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned N_EV   = 3;
  localparam int unsigned EV_CMD = 0;
  localparam int unsigned EV_TX  = 1;
  localparam int unsigned EV_RX  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD = 3'd0,
    SEL_TX  = 3'd1,
    SEL_RX  = 3'd2
  } dr_sel_e;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 4'd0,
    OP_MRD   = 4'd1,
    OP_MWR   = 4'd2,
    OP_MRDS  = 4'd3,
    OP_MWRS  = 4'd4,
    OP_CSRW  = 4'd5,
    OP_HALT  = 4'd6,
    OP_RESET = 4'd7
  } dr_op_e;

  typedef struct packed {
    logic busy;
    logic tx_full;
    logic rx_ready;
  } dr_stat_t;
endpackage

// File: rtl/jdbg_sync.sv
module jdbg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/jdbg_tap_dr.sv
module jdbg_tap_dr
  import jdbg_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              tdo_o,
  output logic [N_EV-1:0]   tgl_o,
  output logic [BYTE_W-1:0] tx_hold_o,
  output logic [OP_W-1:0]   op_hold_o
);
  logic [DR_W-1:0]   sr_q;
  logic [N_EV-1:0]   tgl_q;
  logic [BYTE_W-1:0] tx_hold_q;
  logic [OP_W-1:0]   op_hold_q;
  dr_sel_e           addr;

  assign addr = dr_sel_e'(sr_q[ADDR_W-1:0]);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i && capture_i) begin
      sr_q <= {rx_byte_i, stat_i};
    end else if (sel_i && shift_i) begin
      sr_q <= {tdi_i, sr_q[DR_W-1:1]};
    end
  end

  // each accepted update flips one toggle; payload held until the next one
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q     <= '0;
      tx_hold_q <= '0;
      op_hold_q <= '0;
    end else if (sel_i && update_i) begin
      case (addr)
        SEL_CMD: begin
          op_hold_q     <= sr_q[DR_W-1 -: OP_W];
          tgl_q[EV_CMD] <= ~tgl_q[EV_CMD];
        end
        SEL_TX: begin
          tx_hold_q    <= sr_q[DR_W-1:ADDR_W];
          tgl_q[EV_TX] <= ~tgl_q[EV_TX];
        end
        SEL_RX: tgl_q[EV_RX] <= ~tgl_q[EV_RX];
        default: ;
      endcase
    end
  end

  assign tdo_o     = sr_q[0];
  assign tgl_o     = tgl_q;
  assign tx_hold_o = tx_hold_q;
  assign op_hold_o = op_hold_q;

  // R10
  ignore_addr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && update_i && (sr_q[ADDR_W-1:0] > 3'd2)) |=> $stable(tgl_q));

  // R11
  deselect_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> ($stable(sr_q) && $stable(tgl_q)));
endmodule

// File: rtl/jdbg_sys_ctrl.sv
module jdbg_sys_ctrl
  import jdbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EV-1:0]   tgl_i,
  input  logic [BYTE_W-1:0] tx_hold_i,
  input  logic [OP_W-1:0]   op_hold_i,
  output logic [BYTE_W-1:0] h2c_data_o,
  output logic              h2c_valid_o,
  input  logic              h2c_ready_i,
  input  logic [BYTE_W-1:0] c2h_data_i,
  input  logic              c2h_valid_i,
  output logic              c2h_ready_o,
  output logic              halt_o,
  output logic              reset_o,
  output logic              op_req_o,
  output logic [OP_W-1:0]   op_code_o,
  input  logic              op_done_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic [N_EV-1:0]   tgl_q, ev;
  logic              tx_full_q, rx_ready_q, busy_q;
  logic [BYTE_W-1:0] h2c_q, rx_q;
  logic              halt_q, reset_q, req_q;
  logic [OP_W-1:0]   code_q;
  logic              c2h_take;
  dr_op_e            op;
  dr_stat_t          stat;

  assign ev       = tgl_i ^ tgl_q;
  assign op       = dr_op_e'(op_hold_i);
  assign c2h_take = c2h_valid_i && !rx_ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= '0;
    else         tgl_q <= tgl_i;
  end

  // host-to-CPU slot: first byte wins until the CPU takes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      h2c_q     <= '0;
    end else if (tx_full_q) begin
      if (h2c_ready_i) tx_full_q <= 1'b0;
    end else if (ev[EV_TX]) begin
      tx_full_q <= 1'b1;
      h2c_q     <= tx_hold_i;
    end
  end

  // CPU-to-host slot: byte kept after acknowledge for the trailing capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ready_q <= 1'b0;
      rx_q       <= '0;
    end else if (ev[EV_RX]) begin
      rx_ready_q <= 1'b0;
    end else if (c2h_take) begin
      rx_ready_q <= 1'b1;
      rx_q       <= c2h_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b0;
      reset_q <= 1'b0;
      req_q   <= 1'b0;
      code_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      halt_q  <= 1'b0;
      reset_q <= 1'b0;
      req_q   <= 1'b0;
      if (op_done_i) busy_q <= 1'b0;
      if (ev[EV_CMD]) begin
        case (op)
          OP_HALT:  halt_q  <= 1'b1;
          OP_RESET: reset_q <= 1'b1;
          OP_MRD, OP_MWR, OP_MRDS, OP_MWRS, OP_CSRW: begin
            req_q  <= 1'b1;
            code_q <= op_hold_i;
            busy_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign stat.busy     = busy_q;
  assign stat.tx_full  = tx_full_q;
  assign stat.rx_ready = rx_ready_q;
  assign stat_o        = stat;
  assign rx_byte_o     = rx_q;
  assign h2c_data_o    = h2c_q;
  assign h2c_valid_o   = tx_full_q;
  assign c2h_ready_o   = !rx_ready_q;
  assign halt_o        = halt_q;
  assign reset_o       = reset_q;
  assign op_req_o      = req_q;
  assign op_code_o     = code_q;

  // R7
  halt_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !halt_o);

  // R7
  reset_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> !reset_o);

  // R7
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_o, reset_o, op_req_o}));

  // R8
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o && !op_done_i) |=> (busy_q && !op_req_o));

  // R3
  h2c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2c_valid_o && !h2c_ready_i) |=> (h2c_valid_o && $stable(h2c_data_o)));

  // R5
  c2h_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2h_valid_i && c2h_ready_o) |=> !c2h_ready_o);
endmodule

// File: rtl/jdbg_dr_top.sv
module jdbg_dr_top
  import jdbg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tck_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  input  logic       dr_sel_i,
  input  logic       dr_capture_i,
  input  logic       dr_shift_i,
  input  logic       dr_update_i,
  output logic [7:0] h2c_data_o,
  output logic       h2c_valid_o,
  input  logic       h2c_ready_i,
  input  logic [7:0] c2h_data_i,
  input  logic       c2h_valid_i,
  output logic       c2h_ready_o,
  output logic       cpu_halt_o,
  output logic       cpu_reset_o,
  output logic       op_req_o,
  output logic [3:0] op_code_o,
  input  logic       op_done_i
);
  logic [N_EV-1:0]   tgl_tck, tgl_sys;
  logic [STAT_W-1:0] stat_sys, stat_tck;
  logic [BYTE_W-1:0] tx_hold, rx_byte;
  logic [OP_W-1:0]   op_hold;

  jdbg_tap_dr u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (dr_sel_i),
    .capture_i (dr_capture_i),
    .shift_i   (dr_shift_i),
    .update_i  (dr_update_i),
    .tdi_i     (tdi_i),
    .stat_i    (stat_tck),
    .rx_byte_i (rx_byte),
    .tdo_o     (tdo_o),
    .tgl_o     (tgl_tck),
    .tx_hold_o (tx_hold),
    .op_hold_o (op_hold)
  );

  jdbg_sync #(.W(N_EV), .STAGES(2)) u_ev_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_tck),
    .q_o    (tgl_sys)
  );

  jdbg_sync #(.W(STAT_W), .STAGES(2)) u_stat_sync (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .d_i    (stat_sys),
    .q_o    (stat_tck)
  );

  jdbg_sys_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tgl_i       (tgl_sys),
    .tx_hold_i   (tx_hold),
    .op_hold_i   (op_hold),
    .h2c_data_o  (h2c_data_o),
    .h2c_valid_o (h2c_valid_o),
    .h2c_ready_i (h2c_ready_i),
    .c2h_data_i  (c2h_data_i),
    .c2h_valid_i (c2h_valid_i),
    .c2h_ready_o (c2h_ready_o),
    .halt_o      (cpu_halt_o),
    .reset_o     (cpu_reset_o),
    .op_req_o    (op_req_o),
    .op_code_o   (op_code_o),
    .op_done_i   (op_done_i),
    .stat_o      (stat_sys),
    .rx_byte_o   (rx_byte)
  );
endmodule

// File: tb/sim_jdbg_dr_top.sv
`timescale 1ns/1ps
module sim_jdbg_dr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tck = 1'b0;
  logic       tdi = 1'b0;
  logic       tdo;
  logic       sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0;
  logic [7:0] h2c_data;
  logic       h2c_valid;
  logic       h2c_ready = 1'b0;
  logic [7:0] c2h_data = 8'h00;
  logic       c2h_valid = 1'b0;
  logic       c2h_ready;
  logic       halt, rreq, opreq, op_done = 1'b0;
  logic [3:0] opcode;

  int n_chk = 0, n_bad = 0;
  int halt_cnt = 0, rst_cnt = 0, req_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  jdbg_dr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .tdi_i(tdi), .tdo_o(tdo),
    .dr_sel_i(sel), .dr_capture_i(cap), .dr_shift_i(shf), .dr_update_i(upd),
    .h2c_data_o(h2c_data), .h2c_valid_o(h2c_valid), .h2c_ready_i(h2c_ready),
    .c2h_data_i(c2h_data), .c2h_valid_i(c2h_valid), .c2h_ready_o(c2h_ready),
    .cpu_halt_o(halt), .cpu_reset_o(rreq), .op_req_o(opreq),
    .op_code_o(opcode), .op_done_i(op_done)
  );

  always @(negedge clk) begin
    if (halt)  halt_cnt++;
    if (rreq)  rst_cnt++;
    if (opreq) req_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tck_cycle();
    #10 tck = 1'b1;
    #20 tck = 1'b0;
    #10;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tck_cycle();
  endtask

  task automatic scan(input logic s, input logic [10:0] din, output logic [10:0] dout);
    idle(4);
    sel = s;
    cap = 1'b1; tck_cycle(); cap = 1'b0;
    shf = 1'b1;
    for (int i = 0; i < 11; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      tck_cycle();
    end
    shf = 1'b0;
    upd = 1'b1; tck_cycle(); upd = 1'b0;
    sel = 1'b0;
    idle(6);
  endtask

  function automatic logic [10:0] cmd(input logic [3:0] op);
    return {op, 4'b0000, 3'd0};
  endfunction

  task automatic cpu_push(input logic [7:0] b);
    @(negedge clk); c2h_data = b; c2h_valid = 1'b1;
    @(negedge clk); c2h_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_take();
    @(negedge clk); h2c_ready = 1'b1;
    @(negedge clk); h2c_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [10:0] d;
    scan(1'b1, cmd(4'd0), d);
    chk("R1 status", d[2:0], 0);
    chk("R1 c2h_ready", c2h_ready, 1);
    chk("R1 h2c_valid", h2c_valid, 0);
    chk("R1 pulses", halt_cnt + rst_cnt + req_cnt, 0);
  endtask

  task automatic t_rx_read();
    logic [10:0] d;
    cpu_push(8'h4E);
    chk("R5 c2h_ready low", c2h_ready, 0);
    scan(1'b1, cmd(4'd0), d);
    chk("R5 rx_ready", d[0], 1);
    chk("R2 rx byte field", d[10:3], 8'h4E);
    chk("R2 flag bits", d[2:1], 0);
    scan(1'b1, 11'd2, d);
    chk("R6 c2h_ready back", c2h_ready, 1);
    scan(1'b1, cmd(4'd0), d);
    chk("R6 rx_ready clear", d[0], 0);
    chk("R6 byte kept", d[10:3], 8'h4E);
    cpu_push(8'h1D);
    scan(1'b1, cmd(4'd0), d);
    chk("R5 second byte", d[10:0], {8'h1D, 3'b001});
    scan(1'b1, 11'd2, d);
  endtask

  task automatic t_tx();
    logic [10:0] d;
    scan(1'b1, {8'h6B, 3'd1}, d);
    chk("R3 h2c_valid", h2c_valid, 1);
    chk("R3 h2c_data", h2c_data, 8'h6B);
    scan(1'b1, cmd(4'd0), d);
    chk("R3 tx_full", d[1], 1);
    cpu_take();
    chk("R3 valid drops", h2c_valid, 0);
    scan(1'b1, cmd(4'd0), d);
    chk("R3 tx_full clear", d[1], 0);
  endtask

  task automatic t_tx_full_drop();
    logic [10:0] d;
    scan(1'b1, {8'h11, 3'd1}, d);
    scan(1'b1, {8'h22, 3'd1}, d);
    chk("R4 first byte kept", h2c_data, 8'h11);
    cpu_take();
    chk("R4 second dropped", h2c_valid, 0);
  endtask

  task automatic t_halt_reset();
    logic [10:0] d;
    int h0 = halt_cnt, r0 = rst_cnt, q0 = req_cnt;
    scan(1'b1, cmd(4'd6), d);
    chk("R7 halt pulse", halt_cnt - h0, 1);
    chk("R7 no reset on halt", rst_cnt - r0, 0);
    scan(1'b1, cmd(4'd7), d);
    chk("R7 reset pulse", rst_cnt - r0, 1);
    chk("R7 halt unchanged", halt_cnt - h0, 1);
    chk("R7 no service req", req_cnt - q0, 0);
  endtask

  task automatic t_service();
    logic [10:0] d;
    int q0 = req_cnt;
    scan(1'b1, cmd(4'd3), d);
    chk("R8 req pulse", req_cnt - q0, 1);
    chk("R8 opcode", opcode, 3);
    scan(1'b1, cmd(4'd0), d);
    chk("R8 busy set", d[2], 1);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    scan(1'b1, cmd(4'd0), d);
    chk("R8 busy clear", d[2], 0);
    scan(1'b1, cmd(4'd5), d);
    chk("R8 csr opcode", opcode, 5);
    chk("R8 second req", req_cnt - q0, 2);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_noop();
    logic [10:0] d;
    int tot = halt_cnt + rst_cnt + req_cnt;
    scan(1'b1, cmd(4'd0), d);
    chk("R9 no pulse", halt_cnt + rst_cnt + req_cnt - tot, 0);
    chk("R9 status idle", d[2:0], 0);
  endtask

  task automatic t_bad_addr();
    logic [10:0] d;
    int tot = halt_cnt + rst_cnt + req_cnt;
    scan(1'b1, {4'd6, 4'hF, 3'd5}, d);
    scan(1'b1, {8'hAB, 3'd3}, d);
    scan(1'b1, {8'hC7, 3'd7}, d);
    chk("R10 no pulse", halt_cnt + rst_cnt + req_cnt - tot, 0);
    chk("R10 no tx", h2c_valid, 0);
    scan(1'b1, cmd(4'd0), d);
    chk("R10 status", d[2:0], 0);
  endtask

  task automatic t_deselect();
    logic [10:0] d;
    int h0 = halt_cnt;
    scan(1'b0, cmd(4'd6), d);
    scan(1'b0, {8'h5C, 3'd1}, d);
    chk("R11 no halt", halt_cnt - h0, 0);
    chk("R11 no tx", h2c_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rx_read();
    t_tx();
    t_tx_full_drop();
    t_halt_reset();
    t_service();
    t_noop();
    t_bad_addr();
    t_deselect();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule